// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block holds a parameterised bank of interrupt nodes. Each node owns a control word with a pending flag, an enable bit, a 4-bit priority level and a 3-bit group key. The group key is built from an extension bit (most significant) and a 2-bit group field. A source pulse marks its node pending. The block then picks one winner among the enabled pending nodes: the highest level wins, and a tie on level goes to the highest group key. The winner's index and level are presented to the CPU, and a request is raised when that level beats the CPU's current level.

When the CPU enters a service routine it acknowledges the node, and that clears the node's flag. A transfer channel can also service a node. Such a service clears the flag unless the channel reports that its count reached zero with the end-of-transfer interrupt disabled. In that case the flag stays set, so that a normal CPU interrupt follows at the same level. Software reads and writes the control words through a simple port, and a software write to the flag behaves exactly like a hardware set or clear.

Top module: `irq_prio_arb`

## Requirements
- R1: Each control word has this layout: bit 8 is the group extension, bit 7 is the pending flag, bit 6 is the enable bit, bits 5:2 are the level and bits 1:0 are the group field. Bits 15:9 always read as zero, and writes to them have no effect.
- R2: A pulse on `src_req[i]` sets node i's flag whether or not the node is enabled. A source pulse wins over any clear in the same cycle.
- R3: `cpu_ack` with `cpu_ack_idx` = i clears the flag of enabled node i.
- R4: `chan_ack` with `chan_ack_idx` = i clears the flag of enabled node i unless `chan_keep` is high. With `chan_keep` high the flag stays set, and the node keeps requesting at the same level.
- R5: A software write to bit 7 sets or clears the flag just as hardware does, and the new value takes part in arbitration.
- R6: Only nodes with both flag and enable set take part in arbitration. The flag of a disabled node is not cleared by either acknowledge and persists until software clears it.
- R7: Among eligible nodes, the one with the numerically highest level wins (0 is lowest, 15 is highest).
- R8: When levels tie, the highest group key {bit 8, bits 1:0} wins (0 is lowest, 7 is highest).
- R9: `irq_req` is high only when the winning level is strictly greater than `cpu_lvl`, so level 0 never interrupts. `irq_idx` and `irq_lvl` show the winner whenever one exists, and are 0 when none does.
- R10: When several eligible nodes share the winning level and group key, the lowest index wins and `cfg_err` is high.
- R11: The arbitration outputs are registered. They reflect the flag state one clock after the edge that changed it. `reg_rdata` returns the word addressed in the previous cycle.
- R12: A synchronous reset clears every control word and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NODES | Per-node source request pulses |
| reg_we | input | 1 | Control word write strobe |
| reg_addr | input | IDX_W | Node index for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| cpu_lvl | input | 4 | Current CPU priority level |
| cpu_ack | input | 1 | CPU entered a service routine |
| cpu_ack_idx | input | IDX_W | Node acknowledged by the CPU |
| chan_ack | input | 1 | Transfer channel serviced a node |
| chan_ack_idx | input | IDX_W | Node serviced by the channel |
| chan_keep | input | 1 | Channel count hit zero with end-of-transfer interrupt off |
| irq_req | output | 1 | Request forwarded to the CPU |
| irq_idx | output | IDX_W | Winning node index |
| irq_lvl | output | 4 | Winning node level |
| cfg_err | output | 1 | Exact level and group tie among eligible nodes |

## Verification
The bench targets these corner cases:
- **Group key order.** A level tie is resolved by a group key in which the extension bit outranks the 2-bit field. A design that ignored the extension bit, or put it at the wrong end, would pick the wrong node.
- **Lowest-index tie-break.** A duplicated level and group must yield the lowest index together with `cfg_err`. A reversed scan would name the higher node, and a missing duplicate check would leave the error low.
- **Level gating.** A winning level equal to `cpu_lvl`, and a lone level-0 node, must both leave `irq_req` low. A non-strict comparison would interrupt the CPU at its own level.
- **Flag life cycle.** The flag must:
  - survive a channel service with `chan_keep` set;
  - win against an acknowledge in the same cycle;
  - persist on a disabled node that receives an acknowledge.

  Getting any of these wrong loses requests or drops polled state.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W  = 4;
  localparam int GRP_W  = 2;
  localparam int KEY_W  = 1 + GRP_W;
  localparam int REG_W  = 16;
  localparam int CTRL_W = 3 + LVL_W + GRP_W;

  typedef struct packed {
    logic             gx;
    logic             ir;
    logic             en;
    logic [LVL_W-1:0] lvl;
    logic [GRP_W-1:0] grp;
  } node_ctrl_t;

  function automatic logic [LVL_W+KEY_W-1:0] rank_of(node_ctrl_t c);
    return {c.lvl, c.gx, c.grp};
  endfunction
endpackage

// File: rtl/irq_node_bank.sv
module irq_node_bank
  import irq_arb_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] src_req,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  node_ctrl_t       wr_val,
  input  logic             cpu_ack,
  input  logic [IDX_W-1:0] cpu_ack_idx,
  input  logic             chan_ack,
  input  logic [IDX_W-1:0] chan_ack_idx,
  input  logic             chan_keep,
  output node_ctrl_t       ctrl [NODES]
);
  node_ctrl_t nxt [NODES];

  // Order of effects: software write, then acknowledge clears, then source set.
  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      nxt[i] = ctrl[i];
      if (wr_en && wr_idx == IDX_W'(i)) nxt[i] = wr_val;
      if (ctrl[i].en &&
          ((cpu_ack && cpu_ack_idx == IDX_W'(i)) ||
           (chan_ack && !chan_keep && chan_ack_idx == IDX_W'(i))))
        nxt[i].ir = 1'b0;
      if (src_req[i]) nxt[i].ir = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NODES; i++) begin
      if (rst) ctrl[i] <= '0;
      else     ctrl[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int RK_W  = LVL_W + KEY_W
) (
  input  node_ctrl_t       ctrl [NODES],
  output logic             found,
  output logic [IDX_W-1:0] win_idx,
  output logic [LVL_W-1:0] win_lvl,
  output logic             dup
);
  logic [NODES-1:0] cand;
  logic [RK_W-1:0]  rank [NODES];
  logic [RK_W-1:0]  best;

  for (genvar g = 0; g < NODES; g++) begin : g_cand
    assign cand[g] = ctrl[g].en & ctrl[g].ir;
    assign rank[g] = rank_of(ctrl[g]);
  end

  // Strict compare while scanning upward keeps the lowest index on a tie.
  always_comb begin
    found   = 1'b0;
    best    = '0;
    win_idx = '0;
    for (int i = 0; i < NODES; i++) begin
      if (cand[i] && (!found || rank[i] > best)) begin
        found   = 1'b1;
        best    = rank[i];
        win_idx = IDX_W'(i);
      end
    end
    win_lvl = best[RK_W-1 -: LVL_W];
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NODES; i++)
      if (cand[i] && rank[i] == best && win_idx != IDX_W'(i)) dup = 1'b1;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] src_req,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0] cpu_lvl,
  input  logic             cpu_ack,
  input  logic [IDX_W-1:0] cpu_ack_idx,
  input  logic             chan_ack,
  input  logic [IDX_W-1:0] chan_ack_idx,
  input  logic             chan_keep,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_idx,
  output logic [LVL_W-1:0] irq_lvl,
  output logic             cfg_err
);
  node_ctrl_t       ctrl [NODES];
  node_ctrl_t       wr_val;
  logic             found, dup;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic [NODES-1:0] ir_vec, en_vec;

  assign wr_val = node_ctrl_t'(reg_wdata[CTRL_W-1:0]);

  irq_node_bank #(.NODES(NODES)) bank_i (
    .clk, .rst, .src_req,
    .wr_en(reg_we), .wr_idx(reg_addr), .wr_val,
    .cpu_ack, .cpu_ack_idx, .chan_ack, .chan_ack_idx, .chan_keep,
    .ctrl
  );

  irq_pick #(.NODES(NODES)) pick_i (
    .ctrl, .found, .win_idx, .win_lvl, .dup
  );

  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      ir_vec[i] = ctrl[i].ir;
      en_vec[i] = ctrl[i].en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_idx   <= '0;
      irq_lvl   <= '0;
      cfg_err   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq_req <= found && (win_lvl > cpu_lvl);
      irq_idx <= found ? win_idx : '0;
      irq_lvl <= found ? win_lvl : '0;
      cfg_err <= found && dup;
      if (int'(reg_addr) < NODES)
        reg_rdata <= {{(REG_W-CTRL_W){1'b0}}, ctrl[reg_addr]};
      else
        reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [NODES-1:0] src_req,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_addr,
  input logic [REG_W-1:0] reg_rdata,
  input logic [LVL_W-1:0] cpu_lvl,
  input logic             cpu_ack,
  input logic [IDX_W-1:0] cpu_ack_idx,
  input logic             chan_ack,
  input logic [IDX_W-1:0] chan_ack_idx,
  input logic             chan_keep,
  input logic             irq_req,
  input logic [IDX_W-1:0] irq_idx,
  input logic [LVL_W-1:0] irq_lvl,
  input logic [NODES-1:0] ir_vec,
  input logic [NODES-1:0] en_vec
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:CTRL_W] == '0); // R1

  AST_IRQ_ABOVE_CPU: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_lvl > $past(cpu_lvl)); // R9

  AST_IRQ_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (($past(en_vec & ir_vec) >> irq_idx) & NODES'(1)) != '0); // R6

  for (genvar g = 0; g < NODES; g++) begin : g_node
    AST_SRC_SETS: assert property (@(posedge clk) disable iff (rst)
      src_req[g] |=> ir_vec[g]); // R2

    AST_CPU_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack && cpu_ack_idx == IDX_W'(g) && en_vec[g] && !src_req[g])
        |=> !ir_vec[g]); // R3

    AST_CHAN_KEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (chan_ack && chan_keep && chan_ack_idx == IDX_W'(g) && ir_vec[g] &&
       !(reg_we && reg_addr == IDX_W'(g))) |=> ir_vec[g]); // R4

    AST_DISABLED_PERSISTS: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[g] && ir_vec[g] && !(reg_we && reg_addr == IDX_W'(g)))
        |=> ir_vec[g]); // R6
  end
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.NODES(NODES)) chk_i (
  .clk(clk), .rst(rst), .src_req(src_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .cpu_lvl(cpu_lvl),
  .cpu_ack(cpu_ack), .cpu_ack_idx(cpu_ack_idx), .chan_ack(chan_ack),
  .chan_ack_idx(chan_ack_idx), .chan_keep(chan_keep), .irq_req(irq_req),
  .irq_idx(irq_idx), .irq_lvl(irq_lvl), .ir_vec(ir_vec), .en_vec(en_vec)
);

// File: tb/irq_prio_arb_tb_top.sv
module irq_prio_arb_tb_top;
  localparam int NODES = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NODES-1:0] src_req = '0;
  logic             reg_we = 1'b0;
  logic [IDX_W-1:0] reg_addr = '0;
  logic [15:0]      reg_wdata = '0;
  logic [15:0]      reg_rdata;
  logic [3:0]       cpu_lvl = '0;
  logic             cpu_ack = 1'b0;
  logic [IDX_W-1:0] cpu_ack_idx = '0;
  logic             chan_ack = 1'b0;
  logic [IDX_W-1:0] chan_ack_idx = '0;
  logic             chan_keep = 1'b0;
  logic             irq_req;
  logic [IDX_W-1:0] irq_idx;
  logic [3:0]       irq_lvl;
  logic             cfg_err;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_prio_arb #(.NODES(NODES)) dut_i (
    .clk, .rst, .src_req, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .cpu_lvl, .cpu_ack, .cpu_ack_idx, .chan_ack, .chan_ack_idx, .chan_keep,
    .irq_req, .irq_idx, .irq_lvl, .cfg_err
  );

  // Words for nodes 0..3, CPU level, then expected req, idx, lvl, err.
  typedef struct packed {
    logic [8:0] n0, n1, n2, n3;
    logic [3:0] cpu;
    logic       req;
    logic [2:0] idx;
    logic [3:0] lvl;
    logic       err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{9'h0CC, 9'h0D4, 9'h0C8, 9'h000, 4'd0,  1'b1, 3'd1, 4'd5,  1'b0}, // R7
    '{9'h0D9, 9'h0DB, 9'h1D8, 9'h0D0, 4'd0,  1'b1, 3'd2, 4'd6,  1'b0}, // R8
    '{9'h0A4, 9'h000, 9'h000, 9'h0C8, 4'd0,  1'b1, 3'd3, 4'd2,  1'b0}, // R6
    '{9'h000, 9'h0D0, 9'h000, 9'h000, 4'd4,  1'b0, 3'd1, 4'd4,  1'b0}, // R9
    '{9'h000, 9'h000, 9'h0C0, 9'h000, 4'd0,  1'b0, 3'd2, 4'd0,  1'b0}, // R9
    '{9'h0C4, 9'h0DE, 9'h000, 9'h0DE, 4'd0,  1'b1, 3'd1, 4'd7,  1'b1}, // R10
    '{9'h07C, 9'h000, 9'h000, 9'h000, 4'd0,  1'b0, 3'd0, 4'd0,  1'b0}, // R6
    '{9'h0FC, 9'h000, 9'h000, 9'h000, 4'd14, 1'b1, 3'd0, 4'd15, 1'b0}  // R9
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = IDX_W'(a); reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    reg_addr = IDX_W'(a);
    step();
    d = reg_rdata;
  endtask

  task automatic src_pulse(input int n);
    src_req[n] = 1'b1;
    step();
    src_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    @(negedge clk);
    step();
    rst = 1'b0;
    // R12: reset state
    chk("R12 irq_req", irq_req, 0);
    chk("R12 irq_idx", irq_idx, 0);
    chk("R12 cfg_err", cfg_err, 0);
    rd(2, d);
    chk("R12 rdata", d, 0);

    // Vector walk: write all nodes (R5 sets flags by software), then check.
    for (int v = 0; v < NV; v++) begin
      cpu_lvl = VECS[v].cpu;
      wr(0, {7'd0, VECS[v].n0});
      wr(1, {7'd0, VECS[v].n1});
      wr(2, {7'd0, VECS[v].n2});
      wr(3, {7'd0, VECS[v].n3});
      for (int k = 4; k < NODES; k++) wr(k, 16'h0000);
      step();
      chk($sformatf("R7/R8/R9 vec%0d req", v), irq_req, VECS[v].req);
      chk($sformatf("R7/R8/R10 vec%0d idx", v), irq_idx, VECS[v].idx);
      chk($sformatf("R7/R9 vec%0d lvl", v), irq_lvl, VECS[v].lvl);
      chk($sformatf("R10 vec%0d err", v), cfg_err, VECS[v].err);
    end
    cpu_lvl = 4'd0;
    for (int k = 0; k < NODES; k++) wr(k, 16'h0000);

    // R1: reserved bits read zero; written bits land in the layout
    wr(5, 16'hFFFF);
    rd(5, d);
    chk("R1 rdata", d, 16'h01FF);
    chk("R5 sw-set req", irq_req, 1);
    chk("R5 sw-set idx", irq_idx, 5);
    wr(5, 16'h0000);
    step();
    chk("R5 sw-clear req", irq_req, 0);

    // R2/R11: source pulse and one-cycle arbitration latency
    wr(4, 16'h0050);
    src_req[4] = 1'b1;
    step();
    src_req = '0;
    chk("R11 latency", irq_req, 0);
    step();
    chk("R2 req", irq_req, 1);
    chk("R2 idx", irq_idx, 4);

    // R3: CPU acknowledge clears
    cpu_ack = 1'b1; cpu_ack_idx = 3'd4;
    step();
    cpu_ack = 1'b0;
    step();
    chk("R3 req", irq_req, 0);
    rd(4, d);
    chk("R3 word", d, 16'h0050);

    // R2: source pulse beats simultaneous acknowledge
    src_req[4] = 1'b1; cpu_ack = 1'b1; cpu_ack_idx = 3'd4;
    step();
    src_req = '0; cpu_ack = 1'b0;
    rd(4, d);
    chk("R2 set wins", d, 16'h00D0);

    // R4: channel service with keep leaves flag; without keep clears
    chan_ack = 1'b1; chan_ack_idx = 3'd4; chan_keep = 1'b1;
    step();
    chan_ack = 1'b0; chan_keep = 1'b0;
    rd(4, d);
    chk("R4 keep word", d, 16'h00D0);
    chk("R4 keep req", irq_req, 1);
    chk("R4 keep lvl", irq_lvl, 4);
    chan_ack = 1'b1;
    step();
    chan_ack = 1'b0;
    rd(4, d);
    chk("R4 clear word", d, 16'h0050);

    // R6: disabled node latches its flag; acknowledges do not clear it
    wr(4, 16'h0010);
    src_pulse(4);
    rd(4, d);
    chk("R6 polled flag", d, 16'h0090);
    cpu_ack = 1'b1; cpu_ack_idx = 3'd4;
    chan_ack = 1'b1; chan_ack_idx = 3'd4;
    step();
    cpu_ack = 1'b0; chan_ack = 1'b0;
    rd(4, d);
    chk("R6 ack ignored", d, 16'h0090);
    chk("R6 no req", irq_req, 0);
    wr(4, 16'h0010);
    rd(4, d);
    chk("R5 sw clear", d, 16'h0010);

    // R12: reset mid-run clears words and outputs
    wr(6, 16'h00FC);
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R12 req after reset", irq_req, 0);
    rd(6, d);
    chk("R12 word after reset", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule